// File: doc/BRIEF.md
# UART Sleep Mode Controller

This block decides when one UART channel may stop its functional clock and its bit-rate clock, and when those clocks must start again. It runs in an always-on clock domain and drives a single clock-enable output. A downstream gating cell uses that output to stop or start the UART core clock and the baud clock.

Sleep is entered only when every part of the channel is quiet. Software must have set both enable bits. The receive line must have been idle long enough, and the transmit path must be drained. The receive FIFO must be empty, and no interrupt may be pending except the two that are allowed during sleep. The receive-line idle detector counts mid-bit sample ticks while the line stays high. Its threshold depends on the programmed character length.

When the block enters sleep, it captures the receive line and the modem input levels. Any later difference from those captured levels wakes the channel, and so does a write strobe to the transmit FIFO. The clock enable comes back in the same cycle as the wake event. After each exit, a short guard window stops the block from going straight back to sleep. Clearing either enable bit while asleep also releases the clocks at once. This lets software reprogram the divisor safely.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: The clock enable stays high unless both the enhanced-functions enable and the sleep enable are high.
- R2: The character-length code maps 0,1,2,3 to 5,6,7,8 bits. `rx_idle` rises on the sample tick that makes the count of consecutive high samples equal 4*bits+12, which is 32, 36, 40 or 44 ticks. Before that tick it is low.
- R3: A sample tick that sees the line low, or any falling edge of the line, clears the idle count and `rx_idle`. While the line stays high the count saturates, so `rx_idle` stays high.
- R4: Sleep is not entered while the transmit FIFO or the transmit shift register reports not empty.
- R5: Sleep is not entered while the receive FIFO holds data.
- R6: Sleep is not entered while any interrupt source other than bit 0 (transmit holding empty) or bit 1 (timeout) of `irq_pend` is pending. Those two bits do not block sleep.
- R7: When all entry conditions hold at a clock edge, `uart_clk_en` is low from that edge on. It stays low until a wake cause occurs.
- R8: While asleep, a change of `rx_in` or of any `modem_in` bit, compared with its level at entry, drives `uart_clk_en` high in the same cycle. So does a `tx_fifo_wr` pulse.
- R9: While asleep, clearing either enable bit drives `uart_clk_en` high in the same cycle.
- R10: After any exit from sleep, `uart_clk_en` stays high for the exit edge plus GUARD_CYC further cycles. If the entry conditions still hold, sleep is entered again on the next edge.
- R11: After reset, `uart_clk_en` is high and `rx_idle` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_fn_en | input | 1 | Enhanced-functions enable bit |
| sleep_en | input | 1 | Sleep enable bit |
| char_len | input | 2 | Character-length code, 0..3 for 5..8 bits |
| bit_tick | input | 1 | One-cycle pulse at the middle of each bit time |
| rx_in | input | 1 | Serial receive line (already synchronised) |
| txf_empty | input | 1 | Transmit FIFO empty flag |
| txsr_empty | input | 1 | Transmit shift register empty flag |
| rxf_empty | input | 1 | Receive FIFO empty flag |
| irq_pend | input | IRQ_W | Pending interrupt sources; bit 0 transmit holding empty, bit 1 timeout |
| modem_in | input | MODEM_W | Modem status input levels (already synchronised) |
| tx_fifo_wr | input | 1 | Transmit FIFO write strobe |
| uart_clk_en | output | 1 | Enable for the UART and baud clocks |
| rx_idle | output | 1 | Receive line idle for the full threshold |

## Verification
The checker assumes that `rx_in`, `modem_in` and the status flags are already synchronous to the always-on clock. It also assumes that `bit_tick` is a single-cycle pulse. The bench drives every input just after the falling clock edge and keeps each tick one cycle wide with a gap after it. The checker also assumes that the flags do not change in the same cycle as a wake event. The bench changes only one cause at a time, so each observed release of the clock comes from exactly one wake or disable event.

// File: rtl/uslp_pkg.sv
package uslp_pkg;

    localparam int CHAR_MIN_BITS = 5;
    localparam int IRQ_THR_IDX   = 0;
    localparam int IRQ_TMO_IDX   = 1;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_SLEEP = 2'd1,
        ST_GUARD = 2'd2
    } slp_state_t;

    typedef struct packed {
        logic enabled;
        logic line_idle;
        logic tx_quiet;
        logic rx_drained;
        logic irq_quiet;
        logic no_write;
    } slp_gate_t;

    function automatic int idle_limit(input logic [1:0] code);
        return 4 * (CHAR_MIN_BITS + int'(code)) + 12;
    endfunction

endpackage

// File: rtl/uslp_idle_det.sv
module uslp_idle_det
    import uslp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       rx_in,
    input  logic [1:0] char_len,
    output logic       rx_idle
);

    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] limit;
    logic             rx_q;
    logic             rx_fall;

    always_comb begin
        limit   = CNT_W'(idle_limit(char_len));
        rx_fall = rx_q & ~rx_in;
        rx_idle = (hi_cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            rx_q   <= 1'b1;
        end else begin
            rx_q <= rx_in;
            if (rx_fall || (bit_tick && !rx_in)) begin
                hi_cnt <= '0;
            end else if (bit_tick && (hi_cnt < limit)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uslp_wake_det.sv
module uslp_wake_det #(
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic               rx_in,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               tx_fifo_wr,
    output logic               wake_evt
);

    logic               rx_cap;
    logic [MODEM_W-1:0] modem_cap;
    logic [MODEM_W-1:0] pin_moved;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_cap    <= 1'b1;
            modem_cap <= '0;
        end else if (capture) begin
            rx_cap    <= rx_in;
            modem_cap <= modem_in;
        end
    end

    for (genvar g = 0; g < MODEM_W; g++) begin : g_pin
        assign pin_moved[g] = modem_in[g] ^ modem_cap[g];
    end

    assign wake_evt = (rx_in ^ rx_cap) | (|pin_moved) | tx_fifo_wr;

endmodule

// File: rtl/uslp_fsm.sv
module uslp_fsm
    import uslp_pkg::*;
#(
    parameter int GUARD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enter_ok,
    input  logic allow,
    input  logic wake_evt,
    output logic enter_pulse,
    output logic wake_now,
    output logic sleep_q
);

    localparam int GW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);

    slp_state_t    st;
    logic [GW-1:0] gcnt;

    always_comb begin
        sleep_q     = (st == ST_SLEEP);
        enter_pulse = (st == ST_AWAKE) && enter_ok;
        wake_now    = sleep_q && (wake_evt || !allow);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_AWAKE;
            gcnt <= '0;
        end else begin
            case (st)
                ST_AWAKE: if (enter_pulse) st <= ST_SLEEP;
                ST_SLEEP: if (wake_now) begin
                    st   <= ST_GUARD;
                    gcnt <= GW'(GUARD_CYC - 1);
                end
                ST_GUARD: begin
                    if (gcnt == '0) st <= ST_AWAKE;
                    else            gcnt <= gcnt - 1'b1;
                end
                default: st <= ST_AWAKE;
            endcase
        end
    end

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uslp_pkg::*;
#(
    parameter int IRQ_W     = 6,
    parameter int MODEM_W   = 4,
    parameter int GUARD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enh_fn_en,
    input  logic               sleep_en,
    input  logic [1:0]         char_len,
    input  logic               bit_tick,
    input  logic               rx_in,
    input  logic               txf_empty,
    input  logic               txsr_empty,
    input  logic               rxf_empty,
    input  logic [IRQ_W-1:0]   irq_pend,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               tx_fifo_wr,
    output logic               uart_clk_en,
    output logic               rx_idle
);

    localparam int MAX_LIMIT = idle_limit(2'd3);
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    logic [IRQ_W-1:0] irq_blocking;
    slp_gate_t        gate;
    logic             allow;
    logic             enter_ok;
    logic             enter_pulse;
    logic             wake_evt;
    logic             wake_now;
    logic             sleep_q;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
        if (i == IRQ_THR_IDX || i == IRQ_TMO_IDX) begin : g_ok
            assign irq_blocking[i] = 1'b0;
        end else begin : g_blk
            assign irq_blocking[i] = irq_pend[i];
        end
    end

    always_comb begin
        allow           = enh_fn_en & sleep_en;
        gate.enabled    = allow;
        gate.line_idle  = rx_idle;
        gate.tx_quiet   = txf_empty & txsr_empty;
        gate.rx_drained = rxf_empty;
        gate.irq_quiet  = ~|irq_blocking;
        gate.no_write   = ~tx_fifo_wr;
        enter_ok        = &gate;
        uart_clk_en     = ~sleep_q | wake_now;
    end

    uslp_idle_det #(.CNT_W(CNT_W)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .rx_in    (rx_in),
        .char_len (char_len),
        .rx_idle  (rx_idle)
    );

    uslp_wake_det #(.MODEM_W(MODEM_W)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .capture    (enter_pulse),
        .rx_in      (rx_in),
        .modem_in   (modem_in),
        .tx_fifo_wr (tx_fifo_wr),
        .wake_evt   (wake_evt)
    );

    uslp_fsm #(.GUARD_CYC(GUARD_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enter_ok    (enter_ok),
        .allow       (allow),
        .wake_evt    (wake_evt),
        .enter_pulse (enter_pulse),
        .wake_now    (wake_now),
        .sleep_q     (sleep_q)
    );

endmodule

// File: rtl/uslp_checker.sv
module uslp_checker #(
    parameter int IRQ_W   = 6,
    parameter int MODEM_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               enh_fn_en,
    input logic               sleep_en,
    input logic               bit_tick,
    input logic               rx_in,
    input logic               txf_empty,
    input logic               txsr_empty,
    input logic               rxf_empty,
    input logic [IRQ_W-1:0]   irq_pend,
    input logic [MODEM_W-1:0] modem_in,
    input logic               tx_fifo_wr,
    input logic               uart_clk_en,
    input logic               rx_idle,
    input logic               sleep_q
);

    logic [IRQ_W-1:0] ok_mask;
    always_comb begin
        ok_mask    = '0;
        ok_mask[0] = 1'b1;
        ok_mask[1] = 1'b1;
    end

    AST_ENABLES_HOLD_CLK: assert property (@(posedge clk) disable iff (rst)
        !(enh_fn_en && sleep_en) |-> uart_clk_en); // R1

    AST_SLEEP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_q) |-> $past(rx_idle)); // R2

    AST_LOW_SAMPLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !rx_in) |=> !rx_idle); // R3

    AST_TX_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!sleep_q && !(txf_empty && txsr_empty)) |=> !sleep_q); // R4

    AST_RX_DATA_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!sleep_q && !rxf_empty) |=> !sleep_q); // R5

    AST_IRQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!sleep_q && |(irq_pend & ~ok_mask)) |=> !sleep_q); // R6

    AST_ASLEEP_GATES: assert property (@(posedge clk) disable iff (rst)
        (sleep_q && $stable(rx_in) && $stable(modem_in) && !tx_fifo_wr
         && enh_fn_en && sleep_en && $past(sleep_q)) |-> !uart_clk_en); // R7

    AST_RX_MOVE_WAKES: assert property (@(posedge clk) disable iff (rst)
        (sleep_q && !$stable(rx_in)) |-> uart_clk_en); // R8

    AST_WRITE_WAKES: assert property (@(posedge clk) disable iff (rst)
        (sleep_q && tx_fifo_wr) |-> uart_clk_en); // R8

    AST_GUARD_AFTER_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_q) |=> !sleep_q); // R10

endmodule

bind uart_sleep_ctrl uslp_checker #(
    .IRQ_W   (IRQ_W),
    .MODEM_W (MODEM_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enh_fn_en   (enh_fn_en),
    .sleep_en    (sleep_en),
    .bit_tick    (bit_tick),
    .rx_in       (rx_in),
    .txf_empty   (txf_empty),
    .txsr_empty  (txsr_empty),
    .rxf_empty   (rxf_empty),
    .irq_pend    (irq_pend),
    .modem_in    (modem_in),
    .tx_fifo_wr  (tx_fifo_wr),
    .uart_clk_en (uart_clk_en),
    .rx_idle     (rx_idle),
    .sleep_q     (sleep_q)
);

// File: tb/tb_uart_sleep_ctrl.sv
module tb_uart_sleep_ctrl;

    localparam int IRQ_W   = 6;
    localparam int MODEM_W = 4;
    localparam int GUARD   = 8;

    logic               clk = 1'b0;
    logic               rst;
    logic               enh_fn_en, sleep_en;
    logic [1:0]         char_len;
    logic               bit_tick, rx_in;
    logic               txf_empty, txsr_empty, rxf_empty;
    logic [IRQ_W-1:0]   irq_pend;
    logic [MODEM_W-1:0] modem_in;
    logic               tx_fifo_wr;
    logic               uart_clk_en, rx_idle;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_sleep_ctrl #(.IRQ_W(IRQ_W), .MODEM_W(MODEM_W), .GUARD_CYC(GUARD)) dut (
        .clk(clk), .rst(rst), .enh_fn_en(enh_fn_en), .sleep_en(sleep_en),
        .char_len(char_len), .bit_tick(bit_tick), .rx_in(rx_in),
        .txf_empty(txf_empty), .txsr_empty(txsr_empty), .rxf_empty(rxf_empty),
        .irq_pend(irq_pend), .modem_in(modem_in), .tx_fifo_wr(tx_fifo_wr),
        .uart_clk_en(uart_clk_en), .rx_idle(rx_idle)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; cyc(1);
            bit_tick = 1'b0; cyc(1);
        end
    endtask

    function automatic int limit_of(input int code);
        return 4 * (5 + code) + 12;
    endfunction

    task automatic make_idle();
        char_len = 2'd0;
        rx_in = 1'b0; tick(1);
        rx_in = 1'b1; tick(limit_of(0));
    endtask

    task automatic t_reset();
        rst = 1'b1; cyc(3);
        rst = 1'b0; cyc(1);
        chk("R11 clk_en", uart_clk_en, 1'b1);
        chk("R11 rx_idle", rx_idle, 1'b0);
    endtask

    task automatic t_thresholds();
        for (int c = 0; c < 4; c++) begin
            char_len = 2'(c);
            rx_in = 1'b0; tick(1);
            rx_in = 1'b1; tick(limit_of(c) - 1);
            chk("R2 before limit", rx_idle, 1'b0);
            tick(1);
            chk("R2 at limit", rx_idle, 1'b1);
        end
    endtask

    task automatic t_idle_reset();
        tick(6);
        chk("R3 saturate", rx_idle, 1'b1);
        rx_in = 1'b0; cyc(1);
        rx_in = 1'b1;
        chk("R3 fall clears", rx_idle, 1'b0);
        tick(limit_of(3));
        chk("R3 recount", rx_idle, 1'b1);
        rx_in = 1'b0; tick(1);
        chk("R3 low tick clears", rx_idle, 1'b0);
        rx_in = 1'b1; cyc(1);
    endtask

    task automatic t_enables();
        enh_fn_en = 1'b1; sleep_en = 1'b0;
        make_idle(); cyc(4);
        chk("R1 sleep_en low", uart_clk_en, 1'b1);
        enh_fn_en = 1'b0; sleep_en = 1'b1; cyc(4);
        chk("R1 enh_fn_en low", uart_clk_en, 1'b1);
    endtask

    task automatic t_blockers();
        txf_empty = 1'b0; enh_fn_en = 1'b1; cyc(4);
        chk("R4 txf busy", uart_clk_en, 1'b1);
        txf_empty = 1'b1; txsr_empty = 1'b0; cyc(4);
        chk("R4 shifter busy", uart_clk_en, 1'b1);
        txsr_empty = 1'b1; rxf_empty = 1'b0; cyc(4);
        chk("R5 rx data", uart_clk_en, 1'b1);
        rxf_empty = 1'b1; irq_pend = 6'b000100; cyc(4);
        chk("R6 other irq", uart_clk_en, 1'b1);
        irq_pend = 6'b100000; cyc(4);
        chk("R6 top irq", uart_clk_en, 1'b1);
    endtask

    task automatic t_entry();
        irq_pend = 6'b000011; #1;
        chk("R7 before edge", uart_clk_en, 1'b1);
        cyc(1);
        chk("R7 entered, R6 allowed irqs", uart_clk_en, 1'b0);
        cyc(6);
        chk("R7 stays asleep", uart_clk_en, 1'b0);
    endtask

    task automatic t_wake_modem();
        modem_in[2] = 1'b1; #1;
        chk("R8 modem wake", uart_clk_en, 1'b1);
        for (int i = 0; i <= GUARD; i++) begin
            cyc(1);
            chk("R10 guard", uart_clk_en, 1'b1);
        end
        cyc(1);
        chk("R10 re-entry", uart_clk_en, 1'b0);
    endtask

    task automatic t_wake_rx();
        rx_in = 1'b0; #1;
        chk("R8 rx wake", uart_clk_en, 1'b1);
        cyc(2);
        rx_in = 1'b1; cyc(GUARD + 4);
        chk("R3 idle lost after rx wake", uart_clk_en, 1'b1);
        make_idle(); cyc(2);
        chk("R7 sleep after re-idle", uart_clk_en, 1'b0);
    endtask

    task automatic t_wake_write();
        tx_fifo_wr = 1'b1; #1;
        chk("R8 write wake", uart_clk_en, 1'b1);
        cyc(1);
        tx_fifo_wr = 1'b0;
        chk("R8 awake after write", uart_clk_en, 1'b1);
        cyc(GUARD + 3);
        chk("R10 sleep after write guard", uart_clk_en, 1'b0);
    endtask

    task automatic t_disable();
        sleep_en = 1'b0; #1;
        chk("R9 sleep_en cleared", uart_clk_en, 1'b1);
        cyc(3);
        chk("R9 held awake", uart_clk_en, 1'b1);
        sleep_en = 1'b1; cyc(GUARD + 3);
        chk("R10 back asleep", uart_clk_en, 1'b0);
        enh_fn_en = 1'b0; #1;
        chk("R9 enh_fn_en cleared", uart_clk_en, 1'b1);
        cyc(1);
        enh_fn_en = 1'b1; cyc(GUARD + 3);
        chk("R10 asleep again", uart_clk_en, 1'b0);
    endtask

    initial begin
        rst = 1'b1; enh_fn_en = 1'b0; sleep_en = 1'b0; char_len = 2'd0;
        bit_tick = 1'b0; rx_in = 1'b1; txf_empty = 1'b1; txsr_empty = 1'b1;
        rxf_empty = 1'b1; irq_pend = '0; modem_in = '0; tx_fifo_wr = 1'b0;
        cyc(1);
        t_reset();
        t_thresholds();
        t_idle_reset();
        t_enables();
        t_blockers();
        t_entry();
        t_wake_modem();
        t_wake_rx();
        t_wake_write();
        t_disable();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule